// File: doc/BRIEF.md
# Serial GPIO Shift-Chain Scanner

The scanner widens a chip's general-purpose I/O through two external shift-register chains. It uses four wires: serial data out, serial data in, a shift clock and a strobe. The output chain shifts bits in serially and holds them in a latch. The input chain loads its pins in parallel and shifts them out serially. The scanner runs frames back to back with no gap. Each frame sends the output register down the output chain and collects the input chain into a captured-input register.

A frame has three parts:
- The strobe falls. This latches the previous frame's output bits and parallel-loads the input chain.
- The strobe stays low for one shift-clock period.
- The strobe rises, and max(output count, input count) bits are shifted on the shared clock.

Each input line has its own interrupt sensitivity. Every enabled status bit feeds one combined interrupt line.

Configuration goes through a simple write port. The address selects the target:

| Address | Target |
|---|---|
| 0 | Output line count |
| 1 | Input line count |
| 2 | Divider |
| 3 | Output values |
| 4 | Interrupt enables |
| 5 | Mode bit 0 per line |
| 6 | Mode bit 1 per line |
| 7 | Write-one-to-clear of edge status |

Top module: `sgpio_scan`

## Requirements
- R1: During and right after reset, the strobe, shift clock and serial data out are low, and the captured inputs, interrupt status and interrupt are zero.
- R2: Each frame holds the strobe low for one shift-clock period, with the shift clock low. The strobe then goes high for exactly max(output count, input count) rising shift-clock edges and falls at the end of the frame.
- R3: The shift-clock half period is H = divider value, or H = 1 when the divider is 0. The shift clock is high for H system cycles out of every 2H.
- R4: In step j of a frame with N steps, the scanner sends output line N-1-j, or 0 when that line is not below the output count. After the frame, output line k therefore sits k stages from the chain input. Serial data out changes only while the shift clock is low.
- R5: In step j the scanner samples serial data in at the rising shift-clock edge as input line j, with input line 0 at the first stage the strobe loads. The captured-input register updates on the clock edge where the strobe falls. Lines at or above the input count read as zero.
- R6: A count written above 64 is treated as 64.
- R7: With both counts zero, the strobe stays low and no shift-clock edge occurs.
- R8: Interrupt mode is {bit1, bit0} per line. Mode 00 is level-high and 01 is level-low. While a line is enabled in a level mode, its status bit follows its captured value.
- R9: Mode 10 is rising edge and 11 is falling edge. The scanner compares each frame's capture with the previous frame's capture. A matching change on an enabled line sets a sticky status bit; any other change does not.
- R10: Writing ones to address 7 clears those edge status bits on the next cycle.
- R11: The interrupt is the OR of all enabled status bits. Disabling a line removes its status. Lines at or above the input count never raise status.
- R12: A write to address 0, 1 or 2 restarts scanning on the next cycle, with the strobe and shift clock low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Configuration address |
| cfg_wdata | input | 64 | Configuration write data |
| sgp_sdo | output | 1 | Serial data to the output chain |
| sgp_sdi | input | 1 | Serial data from the input chain |
| sgp_sclk | output | 1 | Shift clock |
| sgp_strobe | output | 1 | Load/latch strobe, low = load |
| in_val | output | 64 | Captured input lines |
| int_stat | output | 64 | Interrupt status per input line |
| irq | output | 1 | Combined interrupt |

## Verification
Configuration writes reach the registers at the next clock edge, so address 7 clears and enable changes are checked at the falling clock edge right after the write.

A change on an input pin is loaded at the first strobe fall after it. It is captured, along with any edge status, at the second strobe fall. The captured inputs and status are therefore sampled one falling clock edge after the second strobe fall.

The output latch holds valid data from the third strobe fall after a configuration change, because a restart can cut short the frame in flight. The bench waits three strobe falls before checking it.

Shift-clock timing is measured in system cycles between the shift-clock and strobe edges themselves.

// File: rtl/sgpio_scan.sv
module sgpio_scan #(
  parameter int NOUT    = 64,
  parameter int NIN     = 64,
  parameter int DIV_W   = 16,
  parameter int DIV_RST = 4
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic                                   cfg_we,
  input  logic [2:0]                             cfg_addr,
  input  logic [((NOUT > NIN) ? NOUT : NIN)-1:0] cfg_wdata,
  output logic                                   sgp_sdo,
  input  logic                                   sgp_sdi,
  output logic                                   sgp_sclk,
  output logic                                   sgp_strobe,
  output logic [NIN-1:0]                         in_val,
  output logic [NIN-1:0]                         int_stat,
  output logic                                   irq
);
  localparam int DW = (NOUT > NIN) ? NOUT : NIN;
  localparam int CW = $clog2(DW + 1);

  logic [CW-1:0]    oc, ic, nb, bitn, sidx, oidx, wcnt_o, wcnt_i;
  logic [DIV_W-1:0] div, half, hcnt;
  logic [NOUT-1:0]  out_reg;
  logic [NIN-1:0]   en, mlo, mhi, edge_st, in_reg, cap, imask, newv, eset, lvl, w1c;
  logic             shifting, ph, tick, last, restart, fend, obit;

  assign wcnt_o  = (cfg_wdata > DW'(NOUT)) ? CW'(NOUT) : cfg_wdata[CW-1:0];
  assign wcnt_i  = (cfg_wdata > DW'(NIN))  ? CW'(NIN)  : cfg_wdata[CW-1:0];
  assign restart = cfg_we && (cfg_addr <= 3'd2);
  assign w1c     = (cfg_we && cfg_addr == 3'd7) ? cfg_wdata[NIN-1:0] : '0;

  assign half = (div == '0) ? DIV_W'(1) : div;
  assign tick = (hcnt == half - DIV_W'(1));
  assign nb   = (oc > ic) ? oc : ic;
  assign last = (bitn == nb - CW'(1));
  assign fend = !restart && tick && ph && (shifting ? last : (nb == '0));

  assign sidx = shifting ? bitn + CW'(1) : '0;
  assign oidx = nb - CW'(1) - sidx;
  assign obit = (oidx < oc) && (|(out_reg & (NOUT'(1) << oidx)));

  for (genvar g = 0; g < NIN; g++) begin : g_mask
    assign imask[g] = (ic > CW'(g));
  end

  assign in_val   = in_reg & imask;
  assign newv     = cap & imask;
  assign eset     = en & mhi & ((mlo & in_val & ~newv) | (~mlo & newv & ~in_val));
  assign lvl      = en & ~mhi & ((mlo & ~in_val & imask) | (~mlo & in_val));
  assign int_stat = (edge_st & en) | lvl;
  assign irq      = |int_stat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oc <= '0; ic <= '0; div <= DIV_W'(DIV_RST);
      out_reg <= '0; en <= '0; mlo <= '0; mhi <= '0;
      edge_st <= '0; in_reg <= '0; cap <= '0;
      hcnt <= '0; bitn <= '0; ph <= 1'b0; shifting <= 1'b0;
      sgp_sclk <= 1'b0; sgp_strobe <= 1'b0; sgp_sdo <= 1'b0;
    end else begin
      if (cfg_we) begin
        case (cfg_addr)
          3'd0:    oc <= wcnt_o;
          3'd1:    ic <= wcnt_i;
          3'd2:    div <= cfg_wdata[DIV_W-1:0];
          3'd3:    out_reg <= cfg_wdata[NOUT-1:0];
          3'd4:    en <= cfg_wdata[NIN-1:0];
          3'd5:    mlo <= cfg_wdata[NIN-1:0];
          3'd6:    mhi <= cfg_wdata[NIN-1:0];
          default: ;
        endcase
      end
      edge_st <= (edge_st & ~w1c) | (fend ? eset : '0);
      if (fend) in_reg <= newv;

      if (restart) begin
        hcnt <= '0; bitn <= '0; ph <= 1'b0; shifting <= 1'b0; cap <= '0;
        sgp_sclk <= 1'b0; sgp_strobe <= 1'b0; sgp_sdo <= 1'b0;
      end else begin
        hcnt <= tick ? '0 : hcnt + DIV_W'(1);
        if (tick) begin
          if (!shifting) begin
            ph <= ~ph;
            if (ph) cap <= '0;
            if (ph && nb != '0) begin
              shifting   <= 1'b1;
              sgp_strobe <= 1'b1;
              sgp_sdo    <= obit;
              ph         <= 1'b0;
            end
          end else if (!ph) begin
            sgp_sclk <= 1'b1;
            cap      <= cap | (NIN'(sgp_sdi) << bitn);
            ph       <= 1'b1;
          end else begin
            sgp_sclk <= 1'b0;
            ph       <= 1'b0;
            if (last) begin
              shifting   <= 1'b0;
              sgp_strobe <= 1'b0;
              sgp_sdo    <= 1'b0;
              bitn       <= '0;
            end else begin
              bitn    <= bitn + CW'(1);
              sgp_sdo <= obit;
            end
          end
        end
      end
    end
  end
endmodule

// File: rtl/sgpio_scan_chk.sv
module sgpio_scan_chk #(
  parameter int NIN = 64
) (
  input logic           clk,
  input logic           rst_n,
  input logic           cfg_we,
  input logic           sgp_sdo,
  input logic           sgp_sclk,
  input logic           sgp_strobe,
  input logic [NIN-1:0] in_val,
  input logic [NIN-1:0] int_stat
);
  assert_sclk_idle_in_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !sgp_strobe |-> !sgp_sclk);

  assert_sdo_steady_while_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
    sgp_sclk |-> $stable(sgp_sdo));

  assert_capture_at_frame_end_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(in_val) && !$past(cfg_we)) |-> $fell(sgp_strobe));

  assert_status_source_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(int_stat) |-> ($fell(sgp_strobe) || $past(cfg_we)));
endmodule

bind sgpio_scan sgpio_scan_chk #(.NIN(NIN)) u_chk (.*);

// File: tb/sgpio_scan_tb.sv
module sgpio_scan_tb;
  localparam int CLK_NS = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_addr = '0;
  logic [63:0] cfg_wdata = '0;
  logic        sdo, sdi, sclk, stb, irq;
  logic [63:0] in_val, int_stat;
  logic [63:0] ext_in = '0, in_sr = '0, o_sr = '0, o_lat = '0;
  int          pulses = 0, cyc = 0, n_chk = 0, n_fail = 0;

  always #(CLK_NS / 2) clk = ~clk;

  sgpio_scan u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .sgp_sdo(sdo), .sgp_sdi(sdi), .sgp_sclk(sclk), .sgp_strobe(stb),
    .in_val(in_val), .int_stat(int_stat), .irq(irq)
  );

  always @(posedge sclk or negedge stb)
    if (!stb) in_sr <= ext_in;
    else      in_sr <= {1'b0, in_sr[63:1]};
  assign sdi = in_sr[0];
  always @(posedge sclk) o_sr <= {o_sr[62:0], sdo};
  always @(negedge stb) o_lat <= o_sr;
  always @(posedge sclk) pulses++;
  always @(posedge clk) cyc++;

  function automatic logic [63:0] lmask(input int n);
    return (n >= 64) ? '1 : ((64'd1 << n) - 64'd1);
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [63:0] d);
    @(negedge clk); cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic frames(input int n);
    repeat (n) @(negedge stb);
    @(negedge clk);
  endtask

  task automatic frame_pulses(input string tag, input int exp);
    int p0;
    @(posedge stb); p0 = pulses;
    @(negedge stb);
    chk(tag, 64'(pulses - p0), 64'(exp));
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    chk("R1 strobe", {63'd0, stb}, 64'd0);
    chk("R1 sclk", {63'd0, sclk}, 64'd0);
    chk("R1 sdo", {63'd0, sdo}, 64'd0);
    chk("R1 in_val", in_val, 64'd0);
    chk("R1 status/irq", int_stat | {63'd0, irq}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after release", {61'd0, stb, sclk, irq}, 64'd0);
  endtask

  task automatic t_full(input logic [63:0] a, input logic [63:0] b);
    wr(3'd2, 64'd1); wr(3'd0, 64'd64); wr(3'd1, 64'd64); wr(3'd3, a);
    ext_in = b;
    frames(3);
    chk("R4 output latch", o_lat, a);
    chk("R5 captured inputs", in_val, b);
    frame_pulses("R2 shift edges per frame", 64);
  endtask

  task automatic t_unequal;
    wr(3'd0, 64'd5); wr(3'd1, 64'd64); wr(3'd3, 64'hFFFF_0000_0000_001A);
    ext_in = 64'h0123_4567_89AB_CDEF;
    frames(3);
    chk("R4 short output chain", o_lat & lmask(5), 64'h1A);
    chk("R5 long input chain", in_val, 64'h0123_4567_89AB_CDEF);
    wr(3'd0, 64'd64); wr(3'd1, 64'd3);
    ext_in = 64'hFFFF_FFFF_FFFF_FFFD;
    frames(2);
    chk("R5 lines above count read zero", in_val, 64'h5);
  endtask

  task automatic t_div;
    int a, b, c;
    wr(3'd2, 64'd3); wr(3'd0, 64'd4); wr(3'd1, 64'd4);
    @(posedge stb);
    @(posedge sclk); a = cyc;
    @(negedge sclk); b = cyc;
    @(posedge sclk); c = cyc;
    chk("R3 high time div=3", 64'(b - a), 64'd3);
    chk("R3 period div=3", 64'(c - a), 64'd6);
    @(negedge stb); a = cyc;
    @(posedge stb); b = cyc;
    chk("R2 strobe low one shift period", 64'(b - a), 64'd6);
    wr(3'd2, 64'd0);
    @(posedge stb);
    @(posedge sclk); a = cyc;
    @(posedge sclk); c = cyc;
    chk("R3 divider zero is divide-by-two", 64'(c - a), 64'd2);
    wr(3'd2, 64'd1);
  endtask

  task automatic t_clamp;
    wr(3'd0, 64'd100); wr(3'd1, 64'd0); wr(3'd3, 64'h8000_0000_0000_0001);
    frame_pulses("R6 count clamped to 64", 64);
    frames(2);
    chk("R6 clamped chain contents", o_lat, 64'h8000_0000_0000_0001);
  endtask

  task automatic t_zero;
    int p0;
    wr(3'd0, 64'd0); wr(3'd1, 64'd0);
    @(negedge clk); p0 = pulses;
    repeat (200) @(negedge clk);
    chk("R7 no shift edges", 64'(pulses - p0), 64'd0);
    chk("R7 strobe held low", {63'd0, stb}, 64'd0);
  endtask

  task automatic t_restart;
    wr(3'd2, 64'd1); wr(3'd0, 64'd64); wr(3'd1, 64'd64);
    ext_in = 64'hDEAD_BEEF_0BAD_F00D;
    @(posedge stb);
    repeat (11) @(negedge clk);
    wr(3'd1, 64'd64);
    chk("R12 restart drops strobe and sclk", {62'd0, stb, sclk}, 64'd0);
    frames(2);
    chk("R12 capture after restart", in_val, 64'hDEAD_BEEF_0BAD_F00D);
  endtask

  task automatic t_irq;
    logic [63:0] en;
    en = (64'd1 << 2) | (64'd1 << 5) | (64'd1 << 7) | (64'd1 << 9);
    wr(3'd2, 64'd1); wr(3'd0, 64'd0); wr(3'd1, 64'd16);
    wr(3'd5, (64'd1 << 5) | (64'd1 << 9));
    wr(3'd6, (64'd1 << 7) | (64'd1 << 9));
    ext_in = 64'd0;
    frames(2);
    wr(3'd4, en); wr(3'd7, '1);
    chk("R8 level-low active", int_stat, 64'd1 << 5);
    chk("R11 irq with status", {63'd0, irq}, 64'd1);
    ext_in = (64'd1 << 2) | (64'd1 << 7);
    frames(2);
    chk("R8 R9 level-high and rising", int_stat, (64'd1 << 2) | (64'd1 << 5) | (64'd1 << 7));
    ext_in = (64'd1 << 2) | (64'd1 << 9);
    frames(2);
    chk("R9 sticky edge, rise ignored on falling line", int_stat,
        (64'd1 << 2) | (64'd1 << 5) | (64'd1 << 7));
    wr(3'd7, 64'd1 << 7);
    chk("R10 write-one-to-clear", int_stat, (64'd1 << 2) | (64'd1 << 5));
    ext_in = (64'd1 << 2) | (64'd1 << 5);
    frames(2);
    chk("R9 falling edge, R8 level-low released", int_stat, (64'd1 << 2) | (64'd1 << 9));
    wr(3'd7, 64'd1 << 9);
    chk("R10 clear falling status", int_stat, 64'd1 << 2);
    wr(3'd4, en | (64'd1 << 20));
    ext_in = (64'd1 << 2) | (64'd1 << 5) | (64'd1 << 20);
    frames(2);
    chk("R11 line above count not captured", in_val, (64'd1 << 2) | (64'd1 << 5));
    chk("R11 line above count no status", int_stat, 64'd1 << 2);
    wr(3'd4, 64'd0);
    chk("R11 disabled gives no irq", int_stat | {63'd0, irq}, 64'd0);
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    #(CLK_NS * 150000);
    n_chk++; n_fail++;
    $display("FAIL R2 watchdog actual=timeout expected=frames complete");
    summary();
    $finish;
  end

  initial begin
    t_reset();
    t_full(64'hA5C3_0F1E_9876_5432, 64'h1357_9BDF_2468_ACE0);
    t_full(64'h0000_0000_0000_0001, 64'h8000_0000_0000_0001);
    t_unequal();
    t_div();
    t_clamp();
    t_zero();
    t_restart();
    t_irq();
    summary();
    $finish;
  end
endmodule